// File: doc/BRIEF.md
# Frame-Aligned Serial Pattern Detector

This block receives a serial bit stream, one bit in each clock cycle where the valid qualifier is high, and cuts it into back-to-back frames of four accepted bits. When a frame is complete, the block reports whether its contents equal one of two fixed target words, 0110 or 1010. Matching is locked to frame boundaries: a target word that straddles two neighbouring frames is never reported. There is no sliding-window search and no resynchronisation.

Both outputs are registered single-cycle pulses. The frame strobe marks every completed frame. The match pulse marks only the completed frames that carry a target word. Idle cycles, where the qualifier is low, hold the frame position. A downstream consumer can therefore count frames and matches without tracking the qualifier itself.

Top module: `frame_pattern_detector`

## Requirements
- R1: A frame is four accepted bits. `frame_done` is high for exactly the one cycle after the fourth accepted bit of every frame, whether or not the frame matched.
- R2: When a completed frame equals 0110, `hit_pulse` is high in the same cycle as `frame_done`.
- R3: When a completed frame equals 1010, `hit_pulse` is high in the same cycle as `frame_done`.
- R4: `hit_pulse` is never high without `frame_done`. A target word formed by bits from two adjacent frames (for example frames 0001 then 1000, or frames 0010 then 1000) produces no match.
- R5: The first accepted bit of a frame is its most significant bit (bit 3). The frame received as 0,1,0,1 is the word 0101 and does not match.
- R6: A cycle with `ser_valid` low neither advances the frame position nor samples `ser_bit`. Both outputs are low in the cycle after such an idle cycle.
- R7: Both outputs are registered pulses that are never high in two consecutive cycles.
- R8: A synchronous active-high `rst` returns the frame position to the start of a frame, discards a partly received frame, and forces both outputs low in the cycle after it is sampled.
- R9: A frame whose leading bits already rule out both targets is still received to its end. The next four accepted bits form a fresh frame that can match (frame 1111 followed by frame 0110 reports one match on the second frame).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ser_bit | input | 1 | Serial data bit, sampled when `ser_valid` is high |
| ser_valid | input | 1 | Qualifier: the data bit is accepted in this cycle |
| hit_pulse | output | 1 | One-cycle pulse: the frame just completed equals a target word |
| frame_done | output | 1 | One-cycle pulse: a frame has just been completed |

## Verification
The bound checker checks on every cycle the properties that need no knowledge of the data:
- the frame strobe follows the count of accepted bits;
- a match never appears without the strobe;
- neither pulse repeats in adjacent cycles;
- idle cycles and reset silence the outputs.

Whether a given frame should match depends on its four data bits. That is shown only by the bench's scenarios: the two target words, bit order, target words straddling a frame boundary, a frame ruled out early, and a reset that lands partway through a frame.

// File: rtl/fpd_pkg.sv
package fpd_pkg;

   // Implementation variant of the match tracker
   typedef enum logic [0:0] {
      TRACK_PER_BIT = 1'b0,   // running "still possible" flag per target
      TRACK_SHIFT   = 1'b1    // collect the frame, compare at its end
   } track_style_e;

   localparam int DEFAULT_FRAME_LEN = 4;
   localparam int DEFAULT_NUM_PAT   = 2;

   // Width of a counter that holds values 0 .. n-1, never below one bit
   function automatic int cnt_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/fpd_position_counter.sv
module fpd_position_counter #(
   parameter int FRAME_LEN = fpd_pkg::DEFAULT_FRAME_LEN,
   localparam int CNT_W    = fpd_pkg::cnt_width(FRAME_LEN)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             accept,
   output logic [CNT_W-1:0] pos
);

   localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_LEN - 1);

   logic [CNT_W-1:0] pos_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pos_q <= '0;
      end else if (accept) begin
         if (pos_q == LAST_POS) begin
            pos_q <= '0;
         end else begin
            pos_q <= pos_q + CNT_W'(1);
         end
      end
   end

   assign pos = pos_q;

endmodule

// File: rtl/fpd_match_tracker.sv
module fpd_match_tracker #(
   parameter int                            FRAME_LEN   = fpd_pkg::DEFAULT_FRAME_LEN,
   parameter int                            NUM_PAT     = fpd_pkg::DEFAULT_NUM_PAT,
   parameter logic [NUM_PAT*FRAME_LEN-1:0]  PATTERNS    = {4'b1010, 4'b0110},
   parameter fpd_pkg::track_style_e         TRACK_STYLE = fpd_pkg::TRACK_PER_BIT,
   localparam int                           CNT_W       = fpd_pkg::cnt_width(FRAME_LEN)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             accept,
   input  logic             ser_bit,
   input  logic [CNT_W-1:0] pos,
   output logic             frame_end,
   output logic             frame_hit
);

   localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_LEN - 1);

   logic at_last;
   logic any_hit;

   assign at_last   = (pos == LAST_POS);
   assign frame_end = accept & at_last;
   assign frame_hit = frame_end & any_hit;

   if (TRACK_STYLE == fpd_pkg::TRACK_PER_BIT) begin : g_per_bit
      // Each target keeps one flag: every bit of this frame so far agreed.
      // The first accepted bit goes to the top bit of the word.
      logic               at_first;
      logic [CNT_W-1:0]   bit_idx;
      logic [NUM_PAT-1:0] alive_q;
      logic [NUM_PAT-1:0] alive_d;

      assign at_first = (pos == '0);
      assign bit_idx  = LAST_POS - pos;

      for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
         localparam logic [FRAME_LEN-1:0] PAT = PATTERNS[p*FRAME_LEN +: FRAME_LEN];
         assign alive_d[p] = (at_first | alive_q[p]) & (ser_bit == PAT[bit_idx]);
      end

      // A frame whose flags are all clear keeps being consumed: the
      // position counter still runs, and the next frame start reloads.
      always_ff @(posedge clk) begin
         if (rst) begin
            alive_q <= '0;
         end else if (accept) begin
            alive_q <= alive_d;
         end
      end

      assign any_hit = |alive_d;
   end else begin : g_shift
      // Keep the last FRAME_LEN-1 accepted bits. At the last position the
      // window plus the incoming bit is exactly the current frame.
      logic [FRAME_LEN-2:0] hist_q;
      logic [FRAME_LEN-1:0] word;
      logic [NUM_PAT-1:0]   eq;

      assign word = {hist_q, ser_bit};

      for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
         localparam logic [FRAME_LEN-1:0] PAT = PATTERNS[p*FRAME_LEN +: FRAME_LEN];
         assign eq[p] = (word == PAT);
      end

      always_ff @(posedge clk) begin
         if (rst) begin
            hist_q <= '0;
         end else if (accept) begin
            hist_q <= word[FRAME_LEN-2:0];
         end
      end

      assign any_hit = |eq;
   end

endmodule

// File: rtl/fpd_pulse_stage.sv
module fpd_pulse_stage (
   input  logic clk,
   input  logic rst,
   input  logic frame_end,
   input  logic frame_hit,
   output logic frame_done,
   output logic hit_pulse
);

   logic done_q;
   logic hit_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         done_q <= 1'b0;
         hit_q  <= 1'b0;
      end else begin
         done_q <= frame_end;
         hit_q  <= frame_hit;
      end
   end

   assign frame_done = done_q;
   assign hit_pulse  = hit_q;

endmodule

// File: rtl/frame_pattern_detector.sv
module frame_pattern_detector #(
   parameter int                            FRAME_LEN   = fpd_pkg::DEFAULT_FRAME_LEN,
   parameter int                            NUM_PAT     = fpd_pkg::DEFAULT_NUM_PAT,
   parameter logic [NUM_PAT*FRAME_LEN-1:0]  PATTERNS    = {4'b1010, 4'b0110},
   parameter fpd_pkg::track_style_e         TRACK_STYLE = fpd_pkg::TRACK_PER_BIT
) (
   input  logic clk,
   input  logic rst,
   input  logic ser_bit,
   input  logic ser_valid,
   output logic hit_pulse,
   output logic frame_done
);

   localparam int CNT_W = fpd_pkg::cnt_width(FRAME_LEN);

   // Parameter checks made while the design is elaborated
   if (FRAME_LEN < 2) begin : g_bad_frame_len
      $error("frame_pattern_detector: FRAME_LEN must be at least 2");
   end
   if (NUM_PAT < 1) begin : g_bad_num_pat
      $error("frame_pattern_detector: NUM_PAT must be at least 1");
   end

   logic [CNT_W-1:0] pos;
   logic             frame_end;
   logic             frame_hit;

   fpd_position_counter #(
      .FRAME_LEN (FRAME_LEN)
   ) u_pos (
      .clk    (clk),
      .rst    (rst),
      .accept (ser_valid),
      .pos    (pos)
   );

   fpd_match_tracker #(
      .FRAME_LEN   (FRAME_LEN),
      .NUM_PAT     (NUM_PAT),
      .PATTERNS    (PATTERNS),
      .TRACK_STYLE (TRACK_STYLE)
   ) u_track (
      .clk       (clk),
      .rst       (rst),
      .accept    (ser_valid),
      .ser_bit   (ser_bit),
      .pos       (pos),
      .frame_end (frame_end),
      .frame_hit (frame_hit)
   );

   fpd_pulse_stage u_out (
      .clk        (clk),
      .rst        (rst),
      .frame_end  (frame_end),
      .frame_hit  (frame_hit),
      .frame_done (frame_done),
      .hit_pulse  (hit_pulse)
   );

endmodule

// File: rtl/frame_pattern_detector_chk.sv
module frame_pattern_detector_chk #(
   parameter int FRAME_LEN = fpd_pkg::DEFAULT_FRAME_LEN
) (
   input logic clk,
   input logic rst,
   input logic ser_valid,
   input logic hit_pulse,
   input logic frame_done
);

   localparam int CW = fpd_pkg::cnt_width(FRAME_LEN);
   localparam logic [CW-1:0] LAST_CNT = CW'(FRAME_LEN - 1);

   // Independent count of accepted bits within the current frame
   logic [CW-1:0] seen_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         seen_q <= '0;
      end else if (ser_valid) begin
         seen_q <= (seen_q == LAST_CNT) ? '0 : seen_q + CW'(1);
      end
   end

   // R1: the strobe follows every last accepted bit of a frame
   a_r1_strobe_on_last: assert property (@(posedge clk) disable iff (rst)
      (ser_valid && seen_q == LAST_CNT) |=> frame_done);

   // R1: the strobe appears nowhere else
   a_r1_no_stray_strobe: assert property (@(posedge clk) disable iff (rst)
      !(ser_valid && seen_q == LAST_CNT) |=> !frame_done);

   // R4: a match only comes with a completed frame
   a_r4_hit_needs_frame: assert property (@(posedge clk) disable iff (rst)
      hit_pulse |-> frame_done);

   // R6: an idle cycle produces no output activity
   a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      !ser_valid |=> (!frame_done && !hit_pulse));

   // R7: the strobe is a single-cycle pulse
   a_r7_strobe_single: assert property (@(posedge clk) disable iff (rst)
      frame_done |=> !frame_done);

   // R7: the match is a single-cycle pulse
   a_r7_hit_single: assert property (@(posedge clk) disable iff (rst)
      hit_pulse |=> !hit_pulse);

   // R8: reset silences both outputs in the following cycle
   a_r8_reset_quiet: assert property (@(posedge clk)
      rst |=> (!frame_done && !hit_pulse));

endmodule

bind frame_pattern_detector frame_pattern_detector_chk #(
   .FRAME_LEN (FRAME_LEN)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .ser_valid  (ser_valid),
   .hit_pulse  (hit_pulse),
   .frame_done (frame_done)
);

// File: tb/tb_frame_pattern_detector.sv
`timescale 1ns/1ps
module tb_frame_pattern_detector;

   logic clk = 1'b0;
   logic rst;
   logic ser_bit;
   logic ser_valid;
   logic hit_pulse;
   logic frame_done;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   frame_pattern_detector dut (
      .clk        (clk),
      .rst        (rst),
      .ser_bit    (ser_bit),
      .ser_valid  (ser_valid),
      .hit_pulse  (hit_pulse),
      .frame_done (frame_done)
   );

   // Each entry: {valid, bit, expected hit_pulse, expected frame_done}.
   // The expectations are for the cycle after the entry is applied.
   localparam int NV = 42;
   localparam logic [3:0] VEC [NV] = '{
      // 0110 -> match (R2)
      4'b1000, 4'b1100, 4'b1100, 4'b1011,
      // 1010 with two idle cycles inside, idle bit value 1 (R3, R6)
      4'b1100, 4'b1000, 4'b0000, 4'b0100, 4'b1100, 4'b1011,
      // 0101: reversed order of 1010, no match (R5)
      4'b1000, 4'b1100, 4'b1000, 4'b1101,
      // 1111: ruled out early, still consumed (R9)
      4'b1100, 4'b1100, 4'b1100, 4'b1101,
      // 0110 right after it -> match (R9, R2)
      4'b1000, 4'b1100, 4'b1100, 4'b1011,
      // 0001 then 1000: 0110 straddles the boundary, no match (R4)
      4'b1000, 4'b1000, 4'b1000, 4'b1101,
      4'b1100, 4'b1000, 4'b1000, 4'b1001,
      // 0010 then 1000: 1010 straddles the boundary, no match (R4)
      4'b1000, 4'b1000, 4'b1100, 4'b1001,
      4'b1100, 4'b1000, 4'b1000, 4'b1001,
      // 1011: plain frame with no match (R1)
      4'b1100, 4'b1000, 4'b1100, 4'b1101
   };

   task automatic check(input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0b expected %0b", what, act, exp);
      end
   endtask

   // Called at a falling edge: drive, wait one cycle, return at the next falling edge
   task automatic step(input logic v, input logic b);
      ser_valid = v;
      ser_bit   = b;
      @(negedge clk);
   endtask

   task automatic send_frame(input logic [3:0] w);
      for (int k = 3; k >= 0; k--) step(1'b1, w[k]);
   endtask

   initial begin
      rst       = 1'b1;
      ser_valid = 1'b0;
      ser_bit   = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check(hit_pulse,  1'b0, "R8 reset state hit_pulse");
      check(frame_done, 1'b0, "R8 reset state frame_done");
      rst = 1'b0;

      // Table walk
      for (int i = 0; i < NV; i++) begin
         step(VEC[i][3], VEC[i][2]);
         check(hit_pulse,  VEC[i][1], $sformatf("R2/R3/R4/R5/R9 vector %0d hit_pulse", i));
         check(frame_done, VEC[i][0], $sformatf("R1/R6 vector %0d frame_done", i));
      end

      // R8: a reset partway through a frame discards the two bits already received
      step(1'b1, 1'b0);
      step(1'b1, 1'b1);
      rst = 1'b1;
      step(1'b1, 1'b1);
      check(frame_done, 1'b0, "R8 mid-frame reset frame_done");
      rst = 1'b0;
      send_frame(4'b0110);
      check(hit_pulse,  1'b1, "R8 frame after mid-frame reset hit_pulse");
      check(frame_done, 1'b1, "R8 frame after mid-frame reset frame_done");

      // R8: a reset that coincides with the would-be last bit
      step(1'b1, 1'b0);
      step(1'b1, 1'b1);
      step(1'b1, 1'b1);
      rst = 1'b1;
      step(1'b1, 1'b0);
      check(hit_pulse,  1'b0, "R8 reset on last bit hit_pulse");
      check(frame_done, 1'b0, "R8 reset on last bit frame_done");
      rst = 1'b0;
      send_frame(4'b1010);
      check(hit_pulse,  1'b1, "R3 frame after reset hit_pulse");
      check(frame_done, 1'b1, "R1 frame after reset frame_done");

      // R7: outputs drop after one cycle even while bits keep arriving
      step(1'b1, 1'b1);
      check(hit_pulse,  1'b0, "R7 hit_pulse single cycle");
      check(frame_done, 1'b0, "R7 frame_done single cycle");

      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired before the scenarios completed");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule